// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Register File

This block is the configuration register file of a four-bank memory controller. Software reaches every register through two bus ports: a pointer port that holds a 32-bit register index, and a data window that reads or writes the register the pointer selects. The file keeps the bus error status pair, an error address, a global configuration word, a read-only status word, the refresh and power-management timers, one configuration word per bank, and the ECC configuration and ECC error status words. Each register applies its own write mask. The timing register's stored value can never be observed, so it is not kept.

A small state machine tracks the global mapping enable. It has two states: `ST_UNMAPPED`, the reset state, and `ST_MAPPED`. Transition `T_MAP` is taken from `ST_UNMAPPED` on a configuration write with bit 31 set. Transition `T_UNMAP` is taken from `ST_MAPPED` on a configuration write with bit 31 clear. Each transition updates status bit 31. A combinational bank decoder uses the bank words and the mapping state to turn a probe address into a one-hot hit vector, an encoded bank index and a miss flag. A level interrupt follows the ECC error status word.

Top module: `memcfg_regfile`

## Requirements
- R1: A write with `bus_sel`=0 stores all 32 bits of `bus_wdata` as the pointer. While `bus_sel`=0, `bus_rdata` returns the pointer.
- R2: While `bus_sel`=1, `bus_rdata` returns the register the pointer selects. The selection is combinational and has no side effects. Index 0x80 (timing) and every index that is not defined return 0xFFFFFFFF. Writes to such indexes change no readable register.
- R3: The bus error status words at indexes 0x00 and 0x08 clear the bits written as 1. The status word at index 0x24 ignores writes.
- R4: Writing the configuration word (index 0x20) stores the data ANDed with 0xFFE00000. `T_MAP` (bit 31 going 0 to 1) clears status bit 31. `T_UNMAP` (bit 31 going 1 to 0) sets status bit 31. Both take effect at the same clock edge as the write.
- R5: When configuration bit 30 goes from 0 to 1, status bit 30 sets. When it goes from 1 to 0, status bit 30 clears. Status bits 29:0 always read 0.
- R6: Per-index write masks apply as follows. The error address (0x10) stores all bits. The refresh timer (0x30) stores data AND 0x3FF80000. The power-management timer (0x34) stores (data AND 0xF8000000) OR 0x07C00000. ECC configuration (0x94) stores data AND 0x00F00000. ECC error status (0x98) stores data AND 0xFFF0F000.
- R7: Bank word b sits at index 0x40+4*b and stores data AND 0xFFDEE001. In that word, bit 0 is the enable, bits 31:23 are the base, and bits 19:17 are the size code.
- R8: Bank b matches address A under four conditions: the mapping state is `ST_MAPPED`, its enable bit is 1, its code c is not 7, and A[31:22+c] equals {base,23'b0}[31:22+c]. In `ST_UNMAPPED` every address misses.
- R9: `hit_vec` has at most one bit set, and that bit marks the lowest-numbered matching bank. `hit_idx` gives the same bank number, or 0 on a miss. `miss` is 1 exactly when no bank matches.
- R10: `ecc_irq` rises on a write that changes the ECC error status from zero to nonzero. It falls on a write that makes it zero. It is visible one edge after the write.
- R11: After reset, the refresh timer is 0x05F00000, the power-management timer 0x07C00000, the configuration 0x00800000, and every other register, the pointer and `ecc_irq` are zero. The state is `ST_UNMAPPED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | 0 selects the pointer port, 1 selects the data window |
| bus_we | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected port (combinational) |
| probe_addr | input | 32 | Address to decode against the banks |
| hit_vec | output | NUM_BANKS | One-hot bank hit |
| hit_idx | output | IDX_W | Encoded bank index of the hit |
| miss | output | 1 | No enabled bank holds the address |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
A wrong mapping state shows at once on the decoder ports. Probes that should hit report `miss`, or the reverse, in the cycle after the configuration write. The same fault appears as a wrong status bit 31 on the next window read. A mis-masked or mis-indexed register surfaces on the first read of its index after the write. A broken priority chain between overlapping banks shows as a wrong `hit_idx` or more than one bit set in `hit_vec` in the same cycle as the probe. A stale interrupt level is seen one edge after the ECC status write.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
    typedef logic [31:0] word_t;

    localparam word_t OFF_BESR0  = 32'h0000_0000;
    localparam word_t OFF_BESR1  = 32'h0000_0008;
    localparam word_t OFF_EADDR  = 32'h0000_0010;
    localparam word_t OFF_CFG    = 32'h0000_0020;
    localparam word_t OFF_STATUS = 32'h0000_0024;
    localparam word_t OFF_RFTIM  = 32'h0000_0030;
    localparam word_t OFF_PMTIM  = 32'h0000_0034;
    localparam word_t OFF_BANK0  = 32'h0000_0040;
    localparam word_t OFF_ECCCFG = 32'h0000_0094;
    localparam word_t OFF_ECCST  = 32'h0000_0098;

    localparam word_t MSK_CFG    = 32'hFFE0_0000;
    localparam word_t MSK_RFTIM  = 32'h3FF8_0000;
    localparam word_t MSK_PMKEEP = 32'hF800_0000;
    localparam word_t PM_FORCED  = 32'h07C0_0000;
    localparam word_t MSK_BANK   = 32'hFFDE_E001;
    localparam word_t MSK_ECCCFG = 32'h00F0_0000;
    localparam word_t MSK_ECCST  = 32'hFFF0_F000;

    localparam word_t RST_RFTIM  = 32'h05F0_0000;
    localparam word_t RST_PMTIM  = 32'h07C0_0000;
    localparam word_t RST_CFG    = 32'h0080_0000;
    localparam word_t RD_NONE    = 32'hFFFF_FFFF;

    localparam int BANK_STRIDE   = 4;
    localparam int SIZE_SHIFT0   = 22;
    localparam logic [2:0] CODE_BAD = 3'd7;

    typedef enum logic {
        ST_UNMAPPED = 1'b0,
        ST_MAPPED   = 1'b1
    } map_state_t;
endpackage

// File: rtl/memcfg_map_fsm.sv
module memcfg_map_fsm
    import memcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       new_en,
    input  logic       new_sr,
    input  logic       old_sr,
    output logic       map_on,
    output logic [1:0] stat_bits
);
    map_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNMAPPED: if (cfg_wr && new_en)  state_d = ST_MAPPED;    // T_MAP
            ST_MAPPED:   if (cfg_wr && !new_en) state_d = ST_UNMAPPED;  // T_UNMAP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNMAPPED;
        else        state_q <= state_d;
    end

    // Output process: status bits follow the named transitions (R4, R5)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_bits <= 2'b00;
        end else begin
            if (state_q == ST_UNMAPPED && state_d == ST_MAPPED) stat_bits[1] <= 1'b0;
            if (state_q == ST_MAPPED && state_d == ST_UNMAPPED) stat_bits[1] <= 1'b1;
            if (cfg_wr && new_sr && !old_sr) stat_bits[0] <= 1'b1;
            if (cfg_wr && !new_sr && old_sr) stat_bits[0] <= 1'b0;
        end
    end

    assign map_on = (state_q == ST_MAPPED);
endmodule

// File: rtl/memcfg_bank_decode.sv
module memcfg_bank_decode
    import memcfg_pkg::*;
#(
    parameter int NB    = 4,
    parameter int IDX_W = 2
)(
    input  logic                 global_en,
    input  logic [NB-1:0]        bank_en,
    input  logic [NB-1:0][8:0]   bank_base,
    input  logic [NB-1:0][2:0]   bank_code,
    input  logic [31:0]          addr,
    output logic [NB-1:0]        hit_vec,
    output logic [IDX_W-1:0]     hit_idx,
    output logic                 miss
);
    logic [NB-1:0] raw_hit;
    logic          found;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [31:0] keep_mask;
        logic [31:0] base_full;
        assign keep_mask  = 32'hFFFF_FFFF << (SIZE_SHIFT0 + int'(bank_code[b]));
        assign base_full  = {bank_base[b], 23'b0};
        assign raw_hit[b] = global_en && bank_en[b] && (bank_code[b] != CODE_BAD)
                            && (((addr ^ base_full) & keep_mask) == 32'h0);
    end

    // Lowest-numbered bank wins on overlap (R9)
    always_comb begin
        hit_vec = '0;
        hit_idx = '0;
        found   = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (raw_hit[b] && !found) begin
                hit_vec[b] = 1'b1;
                hit_idx    = IDX_W'(b);
                found      = 1'b1;
            end
        end
        miss = !found;
    end
endmodule

// File: rtl/memcfg_regfile.sv
module memcfg_regfile
    import memcfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [31:0]          probe_addr,
    output logic [NUM_BANKS-1:0] hit_vec,
    output logic [IDX_W-1:0]     hit_idx,
    output logic                 miss,
    output logic                 ecc_irq
);
    word_t       ptr_q, besr0_q, besr1_q, eaddr_q, rf_q, pm_q, ecccfg_q, eccst_q;
    logic [10:0] cfg_hi_q;            // configuration bits 31:21 (bit 31 unused: held by FSM)
    word_t       bcr_q [NUM_BANKS];
    logic        map_on;
    logic [1:0]  stat_bits;
    word_t       status_q;
    word_t       eccst_new;

    logic ptr_wr, win_wr;
    assign ptr_wr    = bus_we && !bus_sel;
    assign win_wr    = bus_we && bus_sel;
    assign eccst_new = bus_wdata & MSK_ECCST;
    assign status_q  = {stat_bits, 30'b0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            besr0_q  <= '0;
            besr1_q  <= '0;
            eaddr_q  <= '0;
            cfg_hi_q <= RST_CFG[31:21];
            rf_q     <= RST_RFTIM;
            pm_q     <= RST_PMTIM;
            ecccfg_q <= '0;
            eccst_q  <= '0;
            ecc_irq  <= 1'b0;
        end else begin
            if (ptr_wr) ptr_q <= bus_wdata;
            if (win_wr) begin
                unique case (ptr_q)
                    OFF_BESR0:  besr0_q  <= besr0_q & ~bus_wdata;
                    OFF_BESR1:  besr1_q  <= besr1_q & ~bus_wdata;
                    OFF_EADDR:  eaddr_q  <= bus_wdata;
                    OFF_CFG:    cfg_hi_q <= {1'b0, bus_wdata[30:21]};
                    OFF_RFTIM:  rf_q     <= bus_wdata & MSK_RFTIM;
                    OFF_PMTIM:  pm_q     <= (bus_wdata & MSK_PMKEEP) | PM_FORCED;
                    OFF_ECCCFG: ecccfg_q <= bus_wdata & MSK_ECCCFG;
                    OFF_ECCST: begin
                        eccst_q <= eccst_new;
                        if (eccst_q == '0 && eccst_new != '0)      ecc_irq <= 1'b1;
                        else if (eccst_q != '0 && eccst_new == '0) ecc_irq <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    logic [NUM_BANKS-1:0]      bk_en;
    logic [NUM_BANKS-1:0][8:0] bk_base;
    logic [NUM_BANKS-1:0][2:0] bk_code;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bcr
        localparam word_t MY_OFF = OFF_BANK0 + word_t'(BANK_STRIDE * b);
        always_ff @(posedge clk) begin
            if (!rst_n)                         bcr_q[b] <= '0;
            else if (win_wr && ptr_q == MY_OFF) bcr_q[b] <= bus_wdata & MSK_BANK;
        end
        assign bk_en[b]   = bcr_q[b][0];
        assign bk_base[b] = bcr_q[b][31:23];
        assign bk_code[b] = bcr_q[b][19:17];
    end

    memcfg_map_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (win_wr && ptr_q == OFF_CFG),
        .new_en    (bus_wdata[31]),
        .new_sr    (bus_wdata[30]),
        .old_sr    (cfg_hi_q[9]),
        .map_on    (map_on),
        .stat_bits (stat_bits)
    );

    memcfg_bank_decode #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_dec (
        .global_en (map_on),
        .bank_en   (bk_en),
        .bank_base (bk_base),
        .bank_code (bk_code),
        .addr      (probe_addr),
        .hit_vec   (hit_vec),
        .hit_idx   (hit_idx),
        .miss      (miss)
    );

    word_t win_data;
    always_comb begin
        win_data = RD_NONE;
        unique case (ptr_q)
            OFF_BESR0:  win_data = besr0_q;
            OFF_BESR1:  win_data = besr1_q;
            OFF_EADDR:  win_data = eaddr_q;
            OFF_CFG:    win_data = {map_on, cfg_hi_q[9:0], 21'b0};
            OFF_STATUS: win_data = status_q;
            OFF_RFTIM:  win_data = rf_q;
            OFF_PMTIM:  win_data = pm_q;
            OFF_ECCCFG: win_data = ecccfg_q;
            OFF_ECCST:  win_data = eccst_q;
            default:    win_data = RD_NONE;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ptr_q == OFF_BANK0 + word_t'(BANK_STRIDE * b)) win_data = bcr_q[b];
        end
    end

    assign bus_rdata = bus_sel ? win_data : ptr_q;
endmodule

// File: rtl/memcfg_regfile_checker.sv
module memcfg_regfile_checker
    import memcfg_pkg::*;
#(
    parameter int NB    = 4,
    parameter int IDX_W = 2
)(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [31:0]      ptr_q,
    input logic [1:0]       stat_bits,
    input logic             map_on,
    input logic [NB-1:0]    hit_vec,
    input logic [IDX_W-1:0] hit_idx,
    input logic             miss,
    input logic             ecc_irq
);
    logic win_wr;
    assign win_wr = bus_we && bus_sel;

    p_hit_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (hit_vec == '0 && hit_idx == '0));

    p_unmapped_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !map_on |-> miss);

    p_map_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_on) |-> !stat_bits[1]);

    p_unmap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(map_on) |-> stat_bits[1]);

    p_map_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(map_on) |-> $past(win_wr && ptr_q == OFF_CFG));

    p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && ptr_q == OFF_STATUS) |=> $stable(stat_bits));

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ecc_irq) |-> $past(win_wr && ptr_q == OFF_ECCST));
endmodule

bind memcfg_regfile memcfg_regfile_checker #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .ptr_q     (ptr_q),
    .stat_bits (stat_bits),
    .map_on    (map_on),
    .hit_vec   (hit_vec),
    .hit_idx   (hit_idx),
    .miss      (miss),
    .ecc_irq   (ecc_irq)
);

// File: tb/memcfg_regfile_bench.sv
`timescale 1ns/1ps
module memcfg_regfile_bench;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0, probe_addr = '0;
    logic [31:0] bus_rdata;
    logic [NB-1:0] hit_vec;
    logic [1:0]  hit_idx;
    logic        miss, ecc_irq;

    int compared = 0, mismatched = 0;

    always #5 clk = ~clk;

    memcfg_regfile #(.NUM_BANKS(NB)) u_memcfg_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
        .hit_vec(hit_vec), .hit_idx(hit_idx), .miss(miss), .ecc_irq(ecc_irq));

    // Reference model built from the requirements
    logic [31:0] m_ptr, m_eaddr, m_cfg, m_stat, m_rf, m_pm, m_ecccfg, m_eccst;
    logic [31:0] m_bcr [NB];
    logic        m_irq;

    task automatic model_reset();
        m_ptr = 0; m_eaddr = 0; m_cfg = 32'h0080_0000; m_stat = 0;
        m_rf = 32'h05F0_0000; m_pm = 32'h07C0_0000; m_ecccfg = 0; m_eccst = 0;
        m_irq = 0;
        for (int b = 0; b < NB; b++) m_bcr[b] = 0;
    endtask

    function automatic logic [31:0] exp_read(logic [31:0] off);
        case (off)
            32'h00, 32'h08: return 32'h0;
            32'h10: return m_eaddr;
            32'h20: return m_cfg;
            32'h24: return m_stat;
            32'h30: return m_rf;
            32'h34: return m_pm;
            32'h40: return m_bcr[0];
            32'h44: return m_bcr[1];
            32'h48: return m_bcr[2];
            32'h4C: return m_bcr[3];
            32'h94: return m_ecccfg;
            32'h98: return m_eccst;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic model_write(logic [31:0] off, logic [31:0] d);
        logic [31:0] nc, ne;
        case (off)
            32'h10: m_eaddr = d;
            32'h20: begin
                nc = d & 32'hFFE0_0000;
                if (!m_cfg[31] && nc[31]) m_stat[31] = 0;
                if (m_cfg[31] && !nc[31]) m_stat[31] = 1;
                if (!m_cfg[30] && nc[30]) m_stat[30] = 1;
                if (m_cfg[30] && !nc[30]) m_stat[30] = 0;
                m_cfg = nc;
            end
            32'h30: m_rf = d & 32'h3FF8_0000;
            32'h34: m_pm = (d & 32'hF800_0000) | 32'h07C0_0000;
            32'h40: m_bcr[0] = d & 32'hFFDE_E001;
            32'h44: m_bcr[1] = d & 32'hFFDE_E001;
            32'h48: m_bcr[2] = d & 32'hFFDE_E001;
            32'h4C: m_bcr[3] = d & 32'hFFDE_E001;
            32'h94: m_ecccfg = d & 32'h00F0_0000;
            32'h98: begin
                ne = d & 32'hFFF0_F000;
                if (m_eccst == 0 && ne != 0) m_irq = 1;
                else if (m_eccst != 0 && ne == 0) m_irq = 0;
                m_eccst = ne;
            end
            default: ;
        endcase
    endtask

    function automatic int exp_bank(logic [31:0] a);
        logic [31:0] msk;
        int c;
        for (int b = 0; b < NB; b++) begin
            c = int'(m_bcr[b][19:17]);
            msk = 32'hFFFF_FFFF << (22 + c);
            if (m_cfg[31] && m_bcr[b][0] && c != 7 &&
                (((a ^ {m_bcr[b][31:23], 23'b0}) & msk) == 0)) return b;
        end
        return -1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic sel, logic [31:0] d);
        @(negedge clk);
        bus_sel = sel; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        if (!sel) m_ptr = d;
    endtask

    task automatic reg_write(logic [31:0] off, logic [31:0] d);
        bus_write(0, off);
        bus_write(1, d);
        model_write(off, d);
    endtask

    task automatic reg_check(string tag, logic [31:0] off);
        bus_write(0, off);
        bus_sel = 1; #1;
        chk(tag, bus_rdata, exp_read(off));
    endtask

    task automatic dec_check(string tag, logic [31:0] a);
        int e;
        probe_addr = a; #1;
        e = exp_bank(a);
        chk({tag, " miss"}, {31'b0, miss}, {31'b0, e < 0});
        chk({tag, " vec"}, {28'b0, hit_vec}, (e < 0) ? 32'h0 : (32'h1 << e));
        chk({tag, " idx"}, {30'b0, hit_idx}, (e < 0) ? 32'h0 : 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    int offs[16] = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34, 32'h40,
                     32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h04, 32'h5C};

    initial begin
        logic [31:0] a;
        int b;
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R11 reset state
        bus_sel = 0; #1;
        chk("R11 pointer", bus_rdata, 32'h0);
        chk("R11 irq", {31'b0, ecc_irq}, 32'h0);
        for (int i = 0; i < 14; i++) reg_check("R11 reset value", offs[i]);
        dec_check("R11 unmapped", 32'h0);

        // R1 pointer readback
        bus_write(0, 32'hDEAD_BEEF);
        bus_sel = 0; #1;
        chk("R1 pointer", bus_rdata, 32'hDEAD_BEEF);

        // R4/R5 transitions
        reg_write(32'h20, 32'hC01F_FFFF);
        reg_check("R4 cfg mask", 32'h20);
        bus_sel = 1; chk("R4 cfg literal", bus_rdata, 32'hC000_0000);
        reg_check("R5 status set", 32'h24);
        bus_sel = 1; chk("R5 status literal", bus_rdata, 32'h4000_0000);
        reg_write(32'h20, 32'h0);
        reg_check("R4 status after unmap", 32'h24);
        bus_sel = 1; chk("R4 unmap literal", bus_rdata, 32'h8000_0000);

        // R3 read-only status and write-1-to-clear
        reg_write(32'h24, 32'h0000_0000);
        reg_check("R3 status ignores write", 32'h24);
        reg_write(32'h00, 32'hFFFF_FFFF);
        reg_check("R3 besr0", 32'h00);

        // R2 timing and undefined
        reg_write(32'h80, 32'h1234_5678);
        reg_check("R2 timing reads ones", 32'h80);
        reg_check("R2 undefined index", 32'h04);

        // R6 forced power-management bits
        reg_write(32'h34, 32'h0);
        reg_check("R6 pm forced", 32'h34);
        bus_sel = 1; chk("R6 pm literal", bus_rdata, 32'h07C0_0000);

        // R7/R8/R9 banks, overlap, code 7, gating
        reg_write(32'h20, 32'h8000_0000);
        reg_write(32'h40, 32'h1000_0000 | (32'd1 << 17) | 32'h1 | 32'h0021_1FFE);
        reg_check("R7 bank mask", 32'h40);
        reg_write(32'h44, 32'h1000_0001);
        reg_write(32'h48, 32'h0000_0001 | (32'd7 << 17));
        dec_check("R9 overlap low wins", 32'h1000_0004);
        dec_check("R8 inside 8MiB", 32'h107F_FFFC);
        dec_check("R8 outside", 32'h1080_0000);
        dec_check("R8 code7 never", 32'h0000_0100);
        reg_write(32'h40, 32'h1000_0000);
        dec_check("R9 next bank", 32'h1000_0004);
        dec_check("R8 beyond 4MiB", 32'h1050_0000);
        reg_write(32'h20, 32'h0);
        dec_check("R8 global off", 32'h1000_0004);

        // R10 ECC interrupt
        reg_write(32'h98, 32'h0000_0FFF);
        chk("R10 masked zero", {31'b0, ecc_irq}, 32'h0);
        reg_write(32'h98, 32'hFFFF_FFFF);
        chk("R10 rise", {31'b0, ecc_irq}, 32'h1);
        reg_write(32'h98, 32'h0010_0000);
        chk("R10 stay", {31'b0, ecc_irq}, 32'h1);
        reg_write(32'h98, 32'h0);
        chk("R10 fall", {31'b0, ecc_irq}, 32'h0);

        // Random mix (R2 R4 R5 R6 R7 R8 R9 R10)
        for (int it = 0; it < 400; it++) begin
            int o;
            o = offs[$urandom_range(15)];
            reg_write(o, $urandom);
            reg_check("R6 random readback", o);
            reg_check("R5 random status", 32'h24);
            chk("R10 random irq", {31'b0, ecc_irq}, {31'b0, m_irq});
            b = $urandom_range(NB - 1);
            a = {m_bcr[b][31:23], 23'b0} + ($urandom & 32'h00FF_FFFF);
            dec_check("R8 random near base", a);
            dec_check("R9 random addr", $urandom);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule